// File: doc/BRIEF.md
# Wide-Fetch Instruction Prefetch Buffer

This block connects a slow memory that returns 64-bit lines to an instruction decoder that consumes 16-bit halfwords. A fetch always covers an aligned line of four halfwords. An instruction is one or two halfwords long. The block holds two line slots. The first is the line being read. The second is the line that follows it, either already present or still on its way from memory. A new line request goes out in the same cycle a slot is freed, so the memory's multi-cycle latency overlaps with decoding. With a three-cycle memory, the decoder can take one instruction every cycle, as long as no more than four halfwords are consumed in any three cycles.

The decoder side is a valid/ready stream. The block shows the halfword at the current program counter on `out_hw0` and the halfword after it on `out_hw1`. The decoder reports the length of that instruction on `dec_long`. `out_valid` depends on that length: a two-halfword instruction is offered only when both of its halfwords are present, even if they lie in different lines. A transfer happens when `out_valid` and `out_ready` are both high. When `out_ready` is low, the offered instruction and the program counter hold, and fetching stops once both slots are committed. The memory side has no back-pressure. It accepts one request per cycle and answers every request in order after a fixed latency. A redirect on `br_valid` empties both slots, discards any answer still in flight, and restarts fetching at the line that holds the target.

Top module: `wide_fetch_prefetch`

## Requirements
- R1: After reset, `out_valid` is low, `out_pc` equals `RESET_ADDR`, and `mem_req` is high with `mem_addr` equal to the line holding `RESET_ADDR`.
- R2: Line requests are sequential: after a redirect or reset, `mem_addr` takes the target line (halfword address shifted right by 2) and then rises by one per request. Lines held plus lines requested and not yet returned never exceed two.
- R3: Halfword k (0 to 3) of a line is bits [16k+15:16k]. The line at address L covers halfword addresses 4L to 4L+3. `out_hw0` is the halfword at `out_pc`, and `out_hw1` is the halfword at `out_pc`+1.
- R4: `out_valid` is high exactly when the halfword at `out_pc` is held and, if `dec_long` is 1, the halfword at `out_pc`+1 is also held.
- R5: On a transfer, `out_pc` advances by 2 when `dec_long` is 1 and by 1 otherwise. A high `out_ready` without `out_valid` does not change `out_pc`.
- R6: A two-halfword instruction that starts at offset 3 of a line takes its second halfword from offset 0 of the next line. It is offered as soon as both lines are present.
- R7: With a three-cycle memory, no `out_valid` gaps appear after the first instruction in these sequential streams with `out_ready` held high: all short instructions, a long one at offset 2 of every line, and a long one straddling a line boundary every 8 halfwords.
- R8: A redirect drops `out_valid` in the next cycle. The next cycle also issues the target line. The first instruction at the target is offered 4 cycles after the redirect cycle, or 5 cycles if it is long and starts at offset 3. `out_pc` equals the target from the cycle after the redirect.
- R9: Memory answers to requests issued before a redirect are not stored and never appear on the outputs.
- R10: While `out_ready` is low, `out_pc` and `out_hw0` hold, and `mem_req` stays low once both slots are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Redirect request, takes priority over a transfer in the same cycle |
| br_target | input | AW | Halfword address to restart from |
| mem_req | output | 1 | Line request, one per cycle at most |
| mem_addr | output | AW-2 | Line address of the request |
| mem_rvalid | input | 1 | Memory answer valid, in request order |
| mem_rdata | input | 64 | Answered line |
| out_valid | output | 1 | Instruction at `out_pc` is complete |
| out_ready | input | 1 | Decoder takes the offered instruction |
| dec_long | input | 1 | Offered instruction is two halfwords long |
| out_pc | output | AW | Halfword address of the offered instruction |
| out_hw0 | output | 16 | Halfword at `out_pc` |
| out_hw1 | output | 16 | Halfword at `out_pc`+1 |

## Verification
The streams checked are: all-short instructions from an aligned target, a long instruction at offset 2 of every line from a mid-line target, and a long instruction straddling a boundary every eight halfwords starting with a straddle. These three patterns separate a buffer that only covers short code from one that keeps up with mixed lengths and with split instructions. A double redirect, with answers from the first target still in flight, shows whether stale lines are dropped. A test that toggles `dec_long` while only one line is present shows that `out_valid` follows the length. A back-pressure phase shows that the offered data holds and that fetching stops at two lines.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  localparam int HW_W  = 16;
  localparam int SLOTS = 2;
  typedef logic [HW_W-1:0] hw_t;
endpackage

// File: rtl/pfb_fetch_ctrl.sv
module pfb_fetch_ctrl #(
  parameter int AW         = 16,
  parameter int OFS_W      = 2,
  parameter int CNT_W      = 3,
  parameter int RESET_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_valid,
  input  logic [AW-1:0]       br_target,
  input  logic                retire,
  input  logic                mem_rvalid,
  output logic                mem_req,
  output logic [AW-OFS_W-1:0] mem_addr,
  output logic                fill
);
  import pfb_pkg::*;
  localparam int LA_W = AW - OFS_W;
  localparam logic [AW-1:0] RST_PC = AW'(RESET_ADDR);

  logic [1:0]       used_q;   // lines held plus kept requests
  logic [CNT_W-1:0] keep_q;   // in-flight answers to be stored
  logic [CNT_W-1:0] drop_q;   // in-flight answers to be thrown away
  logic [LA_W-1:0]  fa_q;     // next line to request
  logic             arrive_keep;

  assign arrive_keep = mem_rvalid && (drop_q == '0);
  assign fill        = arrive_keep && !br_valid;
  assign mem_req     = !br_valid && ((used_q < 2'(SLOTS)) || retire);
  assign mem_addr    = fa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      keep_q <= '0;
      drop_q <= '0;
      fa_q   <= RST_PC[AW-1:OFS_W];
    end else if (br_valid) begin
      used_q <= '0;
      keep_q <= '0;
      drop_q <= drop_q + keep_q - CNT_W'(mem_rvalid);
      fa_q   <= br_target[AW-1:OFS_W];
    end else begin
      used_q <= used_q + 2'(mem_req) - 2'(retire);
      keep_q <= keep_q + CNT_W'(mem_req) - CNT_W'(arrive_keep);
      drop_q <= drop_q - CNT_W'(mem_rvalid && (drop_q != '0));
      fa_q   <= fa_q + LA_W'(mem_req);
    end
  end

  // R2: committed lines never exceed the two slots
  p_occupancy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= 2'(SLOTS));

  // R8: the cycle after a redirect requests the target line
  p_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(br_valid) && !br_valid |-> mem_req && (mem_addr == $past(br_target[AW-1:OFS_W])));

  // R9: nothing requested before a redirect is stored right after it
  p_stale_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !fill);
endmodule

// File: rtl/pfb_line_store.sv
module pfb_line_store #(
  parameter int AW         = 16,
  parameter int LINE_HW    = 4,
  parameter int RESET_ADDR = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                br_valid,
  input  logic [AW-1:0]                       br_target,
  input  logic                                fill,
  input  logic [LINE_HW*pfb_pkg::HW_W-1:0]    fill_data,
  input  logic                                dec_long,
  input  logic                                out_ready,
  output logic                                out_valid,
  output pfb_pkg::hw_t                        out_hw0,
  output pfb_pkg::hw_t                        out_hw1,
  output logic [AW-1:0]                       out_pc,
  output logic                                retire
);
  import pfb_pkg::*;
  localparam int OFS_W  = $clog2(LINE_HW);
  localparam int LINE_W = LINE_HW * HW_W;

  logic [LINE_W-1:0] cur_q, nxt_q, cur_d, nxt_d;
  logic              cur_v, nxt_v, cur_vd, nxt_vd;
  logic [AW-1:0]     pc_q, pc_d;
  hw_t               cur_hw [LINE_HW];
  hw_t               nxt_hw [LINE_HW];

  for (genvar k = 0; k < LINE_HW; k++) begin : g_split
    assign cur_hw[k] = cur_q[k*HW_W +: HW_W];
    assign nxt_hw[k] = nxt_q[k*HW_W +: HW_W];
  end

  logic [OFS_W-1:0] ofs, ofs1;
  logic             at_last, have0, have1, take;
  logic [OFS_W:0]   ofs_sum;

  assign ofs     = pc_q[OFS_W-1:0];
  assign ofs1    = ofs + OFS_W'(1);          // wraps into the next line
  assign at_last = (ofs == OFS_W'(LINE_HW-1));
  assign have0   = cur_v;
  assign have1   = at_last ? nxt_v : cur_v;
  assign out_hw0 = cur_hw[ofs];
  assign out_hw1 = at_last ? nxt_hw[ofs1] : cur_hw[ofs1];
  assign out_valid = have0 && (!dec_long || have1);
  assign out_pc    = pc_q;

  assign take    = out_valid && out_ready && !br_valid;
  assign ofs_sum = {1'b0, ofs} + (dec_long ? (OFS_W+1)'(2) : (OFS_W+1)'(1));
  assign retire  = take && ofs_sum[OFS_W];

  always_comb begin
    logic [LINE_W-1:0] s0;
    logic              s0v, s1v;
    s0     = retire ? nxt_q : cur_q;
    s0v    = retire ? nxt_v : cur_v;
    s1v    = retire ? 1'b0  : nxt_v;
    cur_d  = s0;
    cur_vd = s0v;
    nxt_d  = nxt_q;
    nxt_vd = s1v;
    if (fill) begin
      if (!s0v) begin
        cur_d  = fill_data;
        cur_vd = 1'b1;
      end else begin
        nxt_d  = fill_data;
        nxt_vd = 1'b1;
      end
    end
    pc_d = take ? pc_q + (dec_long ? AW'(2) : AW'(1)) : pc_q;
    if (br_valid) begin
      cur_vd = 1'b0;
      nxt_vd = 1'b0;
      pc_d   = br_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v <= 1'b0;
      nxt_v <= 1'b0;
      pc_q  <= AW'(RESET_ADDR);
    end else begin
      cur_v <= cur_vd;
      nxt_v <= nxt_vd;
      pc_q  <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    cur_q <= cur_d;
    nxt_q <= nxt_d;
  end

  // R5: a transfer moves the counter by the reported length
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc_q == $past(pc_q) + ($past(dec_long) ? AW'(2) : AW'(1))));

  // R10: a stalled decoder sees a steady counter
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready && !br_valid |=> $stable(out_pc));

  // R8: a redirect empties the offered instruction next cycle
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !out_valid);

  // R2: an arriving line always finds a free slot
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> !(cur_v && nxt_v && !retire));
endmodule

// File: rtl/wide_fetch_prefetch.sv
module wide_fetch_prefetch
  import pfb_pkg::*;
#(
  parameter int AW         = 16,
  parameter int LINE_HW    = 4,
  parameter int CNT_W      = 3,
  parameter int RESET_ADDR = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       br_valid,
  input  logic [AW-1:0]              br_target,
  output logic                       mem_req,
  output logic [AW-$clog2(LINE_HW)-1:0] mem_addr,
  input  logic                       mem_rvalid,
  input  logic [LINE_HW*HW_W-1:0]    mem_rdata,
  output logic                       out_valid,
  input  logic                       out_ready,
  input  logic                       dec_long,
  output logic [AW-1:0]              out_pc,
  output logic [HW_W-1:0]            out_hw0,
  output logic [HW_W-1:0]            out_hw1
);
  localparam int OFS_W = $clog2(LINE_HW);

  logic retire, fill;

  pfb_fetch_ctrl #(
    .AW(AW), .OFS_W(OFS_W), .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
    .retire(retire), .mem_rvalid(mem_rvalid), .mem_req(mem_req),
    .mem_addr(mem_addr), .fill(fill)
  );

  pfb_line_store #(
    .AW(AW), .LINE_HW(LINE_HW), .RESET_ADDR(RESET_ADDR)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
    .fill(fill), .fill_data(mem_rdata), .dec_long(dec_long),
    .out_ready(out_ready), .out_valid(out_valid), .out_hw0(out_hw0),
    .out_hw1(out_hw1), .out_pc(out_pc), .retire(retire)
  );
endmodule

// File: tb/test_wide_fetch_prefetch.sv
module test_wide_fetch_prefetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [15:0] br_target = '0;
  logic        mem_req;
  logic [13:0] mem_addr;
  logic        mem_rvalid;
  logic [63:0] mem_rdata;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        dec_long = 1'b0;
  logic [15:0] out_pc;
  logic [15:0] out_hw0, out_hw1;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wide_fetch_prefetch i_wide_fetch_prefetch (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .dec_long(dec_long), .out_pc(out_pc), .out_hw0(out_hw0), .out_hw1(out_hw1)
  );

  function automatic logic [15:0] mem_hw(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic [63:0] line_data(input logic [13:0] la);
    logic [63:0] d;
    for (int k = 0; k < 4; k++) d[k*16 +: 16] = mem_hw({la, 2'(k)});
    return d;
  endfunction

  // three-cycle memory: request cycle, one wait cycle, answer cycle
  logic        s1_v, s2_v;
  logic [13:0] s1_a, s2_a;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= mem_req;
      s2_v <= s1_v;
    end
    s1_a <= mem_addr;
    s2_a <= s1_a;
  end
  assign mem_rvalid = s2_v;
  assign mem_rdata  = line_data(s2_a);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit long_at(input logic [15:0] pc, input int mode);
    case (mode)
      1: return pc[1:0] == 2'd2;
      2: return pc[2:0] == 3'd3;
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_branch(input logic [15:0] tgt);
    @(negedge clk);
    br_valid  = 1'b1;
    br_target = tgt;
    out_ready = 1'b0;
    dec_long  = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    chk(out_pc == 16'h0, "R1", "pc after reset", out_pc, 0);
    chk(mem_req == 1'b1, "R1", "first request", mem_req, 1);
    chk(mem_addr == 14'h0, "R1", "first line", mem_addr, 0);
  endtask

  task automatic run_stream(input logic [15:0] tgt, input int mode, input int n,
                            input int exp_lat, input string dtag);
    int got = 0, k = 0, first = -1, bubbles = 0;
    int pc_err = 0, dat_err = 0, adr_err = 0;
    logic [15:0] epc   = tgt;
    logic [13:0] eline = tgt[15:2];
    do_branch(tgt);
    while (got < n && k < 80) begin
      @(negedge clk);
      br_valid  = 1'b0;
      k++;
      dec_long  = long_at(out_pc, mode);
      out_ready = 1'b1;
      #1;
      if (mem_req) begin
        if (mem_addr != eline) adr_err++;
        eline++;
      end
      if (out_pc != epc) pc_err++;
      if (out_valid) begin
        if (first < 0) first = k;
        if (out_hw0 != mem_hw(epc)) dat_err++;
        if (dec_long && out_hw1 != mem_hw(epc + 16'd1)) dat_err++;
        got++;
        epc += dec_long ? 16'd2 : 16'd1;
      end else if (first >= 0) begin
        bubbles++;
      end
    end
    chk(first == exp_lat, "R8", "first valid cycle", first, exp_lat);
    chk(bubbles == 0, "R7", "valid gaps", bubbles, 0);
    chk(pc_err == 0, "R5", "pc mismatches", pc_err, 0);
    chk(dat_err == 0, dtag, "halfword mismatches", dat_err, 0);
    chk(adr_err == 0, "R2", "line address mismatches", adr_err, 0);
  endtask

  task automatic test_stream_short();
    run_stream(16'h0040, 0, 24, 4, "R3");
  endtask

  task automatic test_stream_mixed();
    run_stream(16'h0102, 1, 24, 4, "R3");
  endtask

  task automatic test_stream_straddle();
    run_stream(16'h0203, 2, 28, 5, "R6");
  endtask

  task automatic test_stale_discard();
    do_branch(16'h0300);
    @(negedge clk);
    br_valid = 1'b0;
    run_stream(16'h0521, 0, 16, 4, "R9");
  endtask

  task automatic test_backpressure();
    logic [15:0] p0, h0;
    int moved = 0, reqs = 0;
    @(negedge clk);
    out_ready = 1'b0;
    dec_long  = 1'b0;
    #1;
    p0 = out_pc;
    h0 = out_hw0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      #1;
      if (out_pc != p0 || out_hw0 != h0) moved++;
      if (i >= 6 && mem_req) reqs++;
    end
    chk(moved == 0, "R10", "output changes while stalled", moved, 0);
    chk(reqs == 0, "R10", "requests with slots full", reqs, 0);
    chk(out_valid == 1'b1, "R10", "stalled instruction still offered", out_valid, 1);
  endtask

  task automatic test_length_gate();
    do_branch(16'h0707);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      br_valid = 1'b0;
      out_ready = 1'b0;
      dec_long = 1'b1;
    end
    #1;
    chk(out_valid == 1'b0, "R4", "long with one line", out_valid, 0);
    dec_long = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R4", "short with one line", out_valid, 1);
    chk(out_hw0 == mem_hw(16'h0707), "R3", "offset-3 halfword", out_hw0, mem_hw(16'h0707));
    @(negedge clk);
    dec_long = 1'b1;
    #1;
    chk(out_valid == 1'b1, "R6", "long after next line", out_valid, 1);
    chk(out_hw1 == mem_hw(16'h0708), "R6", "second half from next line",
        out_hw1, mem_hw(16'h0708));
    dec_long = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_stream_short();
    test_stream_mixed();
    test_stream_straddle();
    test_stale_discard();
    test_backpressure();
    test_length_gate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule